// File: doc/BRIEF.md
# Flash Command and Interrupt Register Block

This block is the host-facing register front end of a NAND-style flash controller. A host reaches six 16-bit registers over a simple register bus: command, start buffer, two configuration words, controller status and interrupt status. A command write is decoded on the spot. Some opcodes finish at once. Others are handed to an external array engine through a start strobe that carries the opcode and the sector count. The engine answers with a done flag and a fail flag.

The block sets the interrupt-status and error bits that match each result. It drives one interrupt line whose active level is chosen by a configuration bit, and one ready line that follows a configuration bit. While the master interrupt bit is set, new commands are refused. The host acknowledges by clearing bits in the interrupt register, and clearing the master bit also wipes the error flags.

Top module: `flash_cmd_regs`

Register select codes on `regAddr`: 0 command, 1 start buffer, 2 configuration 1, 3 configuration 2, 4 controller status, 5 interrupt status. Any other code reads as zero and ignores writes.

## Requirements
- R1: After the asynchronous cold reset, configuration 1 reads 0x40C0, configuration 2, controller status and command read 0, interrupt status reads 0x8080, readyOut is 1 and busy is 0.
- R2: A write to the command register while interrupt-status bit 15 is set has no effect: the command register keeps its value and no start strobe is issued.
- R3: A write to the interrupt-status register ANDs the written value into it. Whenever bit 15 is clear after the update, controller-status bits 13:10 read zero.
- R4: intrOut equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6, and it follows any change to either register.
- R5: An accepted array opcode raises opStart for exactly one cycle, starting on the clock edge that takes the write. opCode carries the low byte of the written command. busy stays high from that edge until the edge that samples opDone. No completion bit is set before opDone.
- R6: On completion, interrupt-status bit 15 is set together with bit 7 for load opcodes 0x00 and 0x13, bit 6 for program opcodes 0x80, 0x1A and 0x1B, and bit 5 for erase opcodes 0x94 and 0x95 and for resume opcode 0x30.
- R7: A completion that arrives with opFail set also sets status bit 10 and the class error bit: 13 for load, 12 for program, 11 for erase or resume.
- R8: An unrecognised command value sets status bit 10 and interrupt bit 15 in the same edge, and it issues no start strobe.
- R9: Command 0xF0 or 0xF3, or a pulse on warmRstReq, performs a warm reset. It gives the same register values as R1, except that interrupt status becomes 0x8010, and it also drops busy.
- R10: A start-buffer write stores bits 11:8 as the buffer address and bits 1:0 as the count code. Both read back in place. opSectors shows the count, with code 0 meaning 4.
- R11: A configuration-1 write sets readyOut to bit 7 of the written value. Reading configuration 1 returns bits 4:0 as zero.
- R12: A command write while busy is ignored. Opcodes 0x23, 0x27, 0x2A, 0x2C, 0x65 and 0x71 set only interrupt bit 15. Opcode 0xB0 changes no register.
- R13: When an interrupt-status write and an operation completion fall in the same cycle, the AND is applied first and the completion bits and error bits are applied after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low cold reset |
| warmRstReq | input | 1 | Synchronous warm reset pulse |
| regAddr | input | ADDR_W | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write value |
| regRdData | output | 16 | Read value of the selected register |
| opStart | output | 1 | One-cycle start strobe to the array engine |
| opCode | output | 8 | Opcode of the started operation |
| opSectors | output | CNT_W+1 | Sector count, 1 to 2**CNT_W |
| opDone | input | 1 | Array operation finished |
| opFail | input | 1 | Finished operation failed (valid with opDone) |
| busy | output | 1 | An array operation is outstanding |
| intrOut | output | 1 | Interrupt line, level chosen by configuration 1 bit 6 |
| readyOut | output | 1 | Ready line driven from configuration 1 bit 7 |

## Verification
The collision that matters is an interrupt-status write landing in the same cycle that an array operation reports done, and here it reports failure. The bench starts a load, clears the pending flags, and then drives opDone, opFail and a write of zero to the interrupt register on the same clock edge. The result is judged at the ports. Interrupt status must read 0x8080 and controller status 0x2400, which shows that the completion and its errors survived the clear rather than being wiped by it.

// File: rtl/flash_reg_pkg.sv
package flash_reg_pkg;

  localparam int DATA_W = 16;

  // register select codes
  localparam int SEL_CMD  = 0;
  localparam int SEL_BUF  = 1;
  localparam int SEL_CFG1 = 2;
  localparam int SEL_CFG2 = 3;
  localparam int SEL_STAT = 4;
  localparam int SEL_INT  = 5;

  // bit positions
  localparam int ERR_CMD_BIT   = 10;
  localparam int ERR_ERASE_BIT = 11;
  localparam int ERR_PROG_BIT  = 12;
  localparam int ERR_LOAD_BIT  = 13;
  localparam int INT_RST_BIT   = 4;
  localparam int INT_ERASE_BIT = 5;
  localparam int INT_PROG_BIT  = 6;
  localparam int INT_LOAD_BIT  = 7;
  localparam int INT_MASTER    = 15;

  localparam logic [DATA_W-1:0] CFG1_INIT     = 16'h40C0;
  localparam logic [DATA_W-1:0] INT_COLD_INIT = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM_INIT = 16'h8010;

  typedef enum logic [1:0] {
    OPC_NONE  = 2'd0,
    OPC_LOAD  = 2'd1,
    OPC_PROG  = 2'd2,
    OPC_ERASE = 2'd3
  } opClass_e;

  typedef struct packed {
    opClass_e cls;
    logic     immediate;
    logic     warm;
    logic     noop;
  } opInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              cmdAccept;
    logic              warmRst;
    logic [DATA_W-1:0] intSet;
    logic [DATA_W-1:0] errSet;
  } regStrobe_t;

  function automatic opInfo_t decodeOp(input logic [DATA_W-1:0] value);
    opInfo_t info;
    info = '{cls: OPC_NONE, immediate: 1'b0, warm: 1'b0, noop: 1'b0};
    case (value)
      16'h0000, 16'h0013:           info.cls = OPC_LOAD;
      16'h0080, 16'h001A, 16'h001B: info.cls = OPC_PROG;
      16'h0094, 16'h0095, 16'h0030: info.cls = OPC_ERASE;
      16'h0023, 16'h0027, 16'h002A,
      16'h002C, 16'h0065, 16'h0071: info.immediate = 1'b1;
      16'h00F0, 16'h00F3:           info.warm = 1'b1;
      16'h00B0:                     info.noop = 1'b1;
      default: ;
    endcase
    return info;
  endfunction

  function automatic logic [DATA_W-1:0] doneMask(input opClass_e cls);
    logic [DATA_W-1:0] m;
    m = '0;
    case (cls)
      OPC_LOAD:  m[INT_LOAD_BIT]  = 1'b1;
      OPC_PROG:  m[INT_PROG_BIT]  = 1'b1;
      OPC_ERASE: m[INT_ERASE_BIT] = 1'b1;
      default: ;
    endcase
    if (cls != OPC_NONE) m[INT_MASTER] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] failMask(input opClass_e cls);
    logic [DATA_W-1:0] m;
    m = '0;
    case (cls)
      OPC_LOAD:  m[ERR_LOAD_BIT]  = 1'b1;
      OPC_PROG:  m[ERR_PROG_BIT]  = 1'b1;
      OPC_ERASE: m[ERR_ERASE_BIT] = 1'b1;
      default: ;
    endcase
    if (cls != OPC_NONE) m[ERR_CMD_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              warmRstReq,
  input  logic              wrCmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intPend,
  input  logic              opDone,
  input  logic              opFail,
  output regStrobe_t        stb,
  output logic              opStart,
  output logic [7:0]        opCode,
  output logic              busy
);

  opInfo_t  info;
  opClass_e pendCls;
  logic     cmdOk;
  logic     unknownOp;
  logic     finishing;

  always_comb begin
    info      = decodeOp(wrData);
    cmdOk     = wrCmd && !intPend && !busy;
    unknownOp = (info.cls == OPC_NONE) && !info.immediate && !info.warm && !info.noop;
    finishing = busy && opDone;

    stb           = '0;
    stb.cmdAccept = cmdOk;
    stb.warmRst   = warmRstReq || (cmdOk && info.warm);
    if (cmdOk && info.immediate) begin
      stb.intSet[INT_MASTER] = 1'b1;
    end
    if (cmdOk && unknownOp) begin
      stb.intSet[INT_MASTER]  = 1'b1;
      stb.errSet[ERR_CMD_BIT] = 1'b1;
    end
    if (finishing) begin
      stb.intSet = stb.intSet | doneMask(pendCls);
      if (opFail) stb.errSet = stb.errSet | failMask(pendCls);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      opStart <= 1'b0;
      opCode  <= '0;
      pendCls <= OPC_NONE;
    end else if (stb.warmRst) begin
      busy    <= 1'b0;
      opStart <= 1'b0;
    end else begin
      opStart <= 1'b0;
      if (finishing) busy <= 1'b0;
      if (cmdOk && info.cls != OPC_NONE) begin
        busy    <= 1'b1;
        opStart <= 1'b1;
        opCode  <= wrData[7:0];
        pendCls <= info.cls;
      end
    end
  end

  // R5: start strobe is a single cycle and always inside a busy window
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> busy);
  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opDone && !warmRstReq) |=> !busy);

endmodule

// File: rtl/flash_reg_dp.sv
module flash_reg_dp
  import flash_reg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUF_W  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              intPend,
  output logic              intrOut,
  output logic              readyOut,
  output logic [CNT_W:0]    sectorCount
);

  localparam int BUF_LSB = 8;

  logic [DATA_W-1:0] cmdReg, cfg1, cfg2, status, intStat;
  logic [BUF_W-1:0]  bufAddr;
  logic [CNT_W-1:0]  cntCode;
  logic              wrBuf, wrCfg1, wrCfg2, wrInt;
  logic [DATA_W-1:0] intNext, statNext;

  always_comb begin
    wrBuf  = regWrEn && (regAddr == ADDR_W'(SEL_BUF));
    wrCfg1 = regWrEn && (regAddr == ADDR_W'(SEL_CFG1));
    wrCfg2 = regWrEn && (regAddr == ADDR_W'(SEL_CFG2));
    wrInt  = regWrEn && (regAddr == ADDR_W'(SEL_INT));

    // R13: acknowledge first, then completion flags
    intNext = (wrInt ? (intStat & wrData) : intStat) | stb.intSet;
    statNext = status;
    if (!intNext[INT_MASTER]) statNext[ERR_LOAD_BIT:ERR_CMD_BIT] = '0;
    statNext = statNext | stb.errSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      cfg1     <= CFG1_INIT;
      cfg2     <= '0;
      status   <= '0;
      intStat  <= INT_COLD_INIT;
      bufAddr  <= '0;
      cntCode  <= CNT_W'(1);
      readyOut <= 1'b1;
    end else if (stb.warmRst) begin
      cmdReg   <= '0;
      cfg1     <= CFG1_INIT;
      cfg2     <= '0;
      status   <= '0;
      intStat  <= INT_WARM_INIT;
      bufAddr  <= '0;
      cntCode  <= CNT_W'(1);
      readyOut <= 1'b1;
    end else begin
      if (stb.cmdAccept) cmdReg <= wrData;
      if (wrBuf) begin
        bufAddr <= wrData[BUF_LSB +: BUF_W];
        cntCode <= wrData[CNT_W-1:0];
      end
      if (wrCfg1) begin
        cfg1     <= wrData;
        readyOut <= wrData[7];
      end
      if (wrCfg2) cfg2 <= wrData;
      intStat <= intNext;
      status  <= statNext;
    end
  end

  always_comb begin
    intPend     = intStat[INT_MASTER];
    intrOut     = intStat[INT_MASTER] ^ ~cfg1[6];
    sectorCount = (cntCode == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, cntCode};
    rdData      = '0;
    case (regAddr)
      ADDR_W'(SEL_CMD):  rdData = cmdReg;
      ADDR_W'(SEL_BUF): begin
        rdData[BUF_LSB +: BUF_W] = bufAddr;
        rdData[CNT_W-1:0]        = cntCode;
      end
      ADDR_W'(SEL_CFG1): rdData = {cfg1[DATA_W-1:5], 5'b0};
      ADDR_W'(SEL_CFG2): rdData = cfg2;
      ADDR_W'(SEL_STAT): rdData = status;
      ADDR_W'(SEL_INT):  rdData = intStat;
      default: ;
    endcase
  end

  // R3: error flags only live while the master interrupt bit is set
  assert_err_needs_master_R3: assert property (@(posedge clk) disable iff (!rstN)
    !intStat[INT_MASTER] |-> (status[ERR_LOAD_BIT:ERR_CMD_BIT] == '0));
  // R2: a pending interrupt freezes the command register
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (intStat[INT_MASTER] && !stb.warmRst) |=> $stable(cmdReg));
  // R11: ready line takes bit 7 of a configuration-1 write
  assert_ready_follow_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrCfg1 && !stb.warmRst) |=> (readyOut == $past(wrData[7])));

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_reg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUF_W  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              warmRstReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              opStart,
  output logic [7:0]        opCode,
  output logic [CNT_W:0]    opSectors,
  input  logic              opDone,
  input  logic              opFail,
  output logic              busy,
  output logic              intrOut,
  output logic              readyOut
);

  regStrobe_t stb;
  logic       intPend;
  logic       wrCmd;

  assign wrCmd = regWrEn && (regAddr == ADDR_W'(SEL_CMD));

  flash_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .warmRstReq (warmRstReq),
    .wrCmd      (wrCmd),
    .wrData     (regWrData),
    .intPend    (intPend),
    .opDone     (opDone),
    .opFail     (opFail),
    .stb        (stb),
    .opStart    (opStart),
    .opCode     (opCode),
    .busy       (busy)
  );

  flash_reg_dp #(
    .ADDR_W (ADDR_W),
    .BUF_W  (BUF_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .wrData      (regWrData),
    .rdData      (regRdData),
    .intPend     (intPend),
    .intrOut     (intrOut),
    .readyOut    (readyOut),
    .sectorCount (opSectors)
  );

endmodule

// File: tb/flash_cmd_regs_tb.sv
module flash_cmd_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        warmRstReq = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        opStart;
  logic [7:0]  opCode;
  logic [2:0]  opSectors;
  logic        opDone = 1'b0;
  logic        opFail = 1'b0;
  logic        busy, intrOut, readyOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  flash_cmd_regs u_dut (
    .clk(clk), .rstN(rstN), .warmRstReq(warmRstReq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .opStart(opStart), .opCode(opCode),
    .opSectors(opSectors), .opDone(opDone), .opFail(opFail),
    .busy(busy), .intrOut(intrOut), .readyOut(readyOut)
  );

  localparam logic [2:0] A_CMD = 3'd0, A_BUF = 3'd1, A_CFG1 = 3'd2,
                         A_CFG2 = 3'd3, A_STAT = 3'd4, A_INT = 3'd5;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic finishOp(input logic fail);
    @(negedge clk);
    opDone = 1'b1; opFail = fail;
    @(negedge clk);
    opDone = 1'b0; opFail = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(A_CFG1, v); chk("R1 cfg1", v, 16'h40C0);
    rd(A_CFG2, v); chk("R1 cfg2", v, 16'h0000);
    rd(A_STAT, v); chk("R1 status", v, 16'h0000);
    rd(A_INT, v);  chk("R1 int", v, 16'h8080);
    rd(A_CMD, v);  chk("R1 cmd", v, 16'h0000);
    chk("R1 ready", {15'b0, readyOut}, 16'h1);
    chk("R1 busy", {15'b0, busy}, 16'h0);
    chk("R4 intr after reset", {15'b0, intrOut}, 16'h1);
  endtask

  task automatic testBlockedCmd();
    logic [15:0] v;
    wr(A_CMD, 16'h0080);
    chk("R2 no start", {15'b0, opStart}, 16'h0);
    rd(A_CMD, v); chk("R2 cmd unchanged", v, 16'h0000);
    chk("R2 not busy", {15'b0, busy}, 16'h0);
  endtask

  task automatic testAckAndPolarity();
    logic [15:0] v;
    wr(A_INT, 16'h7FFF);
    rd(A_INT, v); chk("R3 and-clear", v, 16'h0080);
    chk("R4 intr low", {15'b0, intrOut}, 16'h0);
    wr(A_INT, 16'h0000);
    rd(A_INT, v); chk("R3 clear all", v, 16'h0000);
    wr(A_CFG1, 16'h0080);
    chk("R4 inverted polarity", {15'b0, intrOut}, 16'h1);
    chk("R11 ready high", {15'b0, readyOut}, 16'h1);
    wr(A_CFG1, 16'h405F);
    rd(A_CFG1, v); chk("R11 low bits masked", v, 16'h4040);
    chk("R11 ready low", {15'b0, readyOut}, 16'h0);
    chk("R4 normal polarity", {15'b0, intrOut}, 16'h0);
    wr(A_CFG1, 16'h40C0);
  endtask

  task automatic testStartBuffer();
    logic [15:0] v;
    wr(A_BUF, 16'h0A03);
    rd(A_BUF, v); chk("R10 readback", v, 16'h0A03);
    chk("R10 count 3", {13'b0, opSectors}, 16'd3);
    wr(A_BUF, 16'h0500);
    rd(A_BUF, v); chk("R10 readback zero code", v, 16'h0500);
    chk("R10 code 0 means 4", {13'b0, opSectors}, 16'd4);
  endtask

  task automatic testLoad();
    logic [15:0] v;
    wr(A_CMD, 16'h0013);
    chk("R5 start", {15'b0, opStart}, 16'h1);
    chk("R5 opcode", {8'b0, opCode}, 16'h0013);
    chk("R5 busy", {15'b0, busy}, 16'h1);
    rd(A_INT, v); chk("R5 no early completion", v, 16'h0000);
    @(negedge clk);
    chk("R5 single pulse", {15'b0, opStart}, 16'h0);
    finishOp(1'b0);
    rd(A_INT, v); chk("R6 load done", v, 16'h8080);
    rd(A_STAT, v); chk("R6 no error", v, 16'h0000);
    chk("R5 busy released", {15'b0, busy}, 16'h0);
    wr(A_INT, 16'h0000);
  endtask

  task automatic testProgFail();
    logic [15:0] v;
    wr(A_CMD, 16'h001A);
    finishOp(1'b1);
    rd(A_INT, v);  chk("R6 program done", v, 16'h8040);
    rd(A_STAT, v); chk("R7 program error", v, 16'h1400);
    wr(A_INT, 16'h7FFF);
    rd(A_INT, v);  chk("R3 master cleared", v, 16'h0040);
    rd(A_STAT, v); chk("R3 errors wiped", v, 16'h0000);
    wr(A_INT, 16'h0000);
  endtask

  task automatic testErase();
    logic [15:0] v;
    wr(A_CMD, 16'h0095);
    finishOp(1'b1);
    rd(A_INT, v);  chk("R6 erase done", v, 16'h8020);
    rd(A_STAT, v); chk("R7 erase error", v, 16'h0C00);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0030);
    finishOp(1'b0);
    rd(A_INT, v);  chk("R6 resume done", v, 16'h8020);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0000);
    finishOp(1'b1);
    rd(A_STAT, v); chk("R7 load error", v, 16'h2400);
    wr(A_INT, 16'h0000);
  endtask

  task automatic testUnknown();
    logic [15:0] v;
    wr(A_CMD, 16'h0055);
    chk("R8 no start", {15'b0, opStart}, 16'h0);
    rd(A_STAT, v); chk("R8 cmd error", v, 16'h0400);
    rd(A_INT, v);  chk("R8 master", v, 16'h8000);
    wr(A_INT, 16'h0000);
  endtask

  task automatic testImmediateAndBusy();
    logic [15:0] v;
    wr(A_CMD, 16'h0023);
    chk("R12 no start", {15'b0, opStart}, 16'h0);
    rd(A_INT, v);  chk("R12 master only", v, 16'h8000);
    rd(A_STAT, v); chk("R12 no error", v, 16'h0000);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h00B0);
    rd(A_INT, v);  chk("R12 suspend no int", v, 16'h0000);
    rd(A_STAT, v); chk("R12 suspend no error", v, 16'h0000);
    wr(A_CMD, 16'h0000);
    wr(A_CMD, 16'h0080);
    rd(A_CMD, v);  chk("R12 busy blocks write", v, 16'h0000);
    chk("R12 opcode kept", {8'b0, opCode}, 16'h0000);
    finishOp(1'b0);
    rd(A_INT, v);  chk("R12 original op completes", v, 16'h8080);
    wr(A_INT, 16'h0000);
  endtask

  task automatic testCollision();
    logic [15:0] v;
    wr(A_CMD, 16'h0000);
    @(negedge clk);
    opDone = 1'b1; opFail = 1'b1;
    regAddr = A_INT; regWrData = 16'h0000; regWrEn = 1'b1;
    @(negedge clk);
    opDone = 1'b0; opFail = 1'b0; regWrEn = 1'b0;
    rd(A_INT, v);  chk("R13 completion survives clear", v, 16'h8080);
    rd(A_STAT, v); chk("R13 errors survive clear", v, 16'h2400);
    wr(A_INT, 16'h0000);
    rd(A_STAT, v); chk("R3 later clear wipes", v, 16'h0000);
  endtask

  task automatic testWarm();
    logic [15:0] v;
    wr(A_CFG2, 16'h1234);
    wr(A_CFG1, 16'h0000);
    wr(A_BUF, 16'h0302);
    wr(A_CMD, 16'h00F0);
    rd(A_INT, v);  chk("R9 int warm", v, 16'h8010);
    rd(A_CFG1, v); chk("R9 cfg1", v, 16'h40C0);
    rd(A_CFG2, v); chk("R9 cfg2", v, 16'h0000);
    rd(A_BUF, v);  chk("R9 buffer", v, 16'h0001);
    chk("R9 ready", {15'b0, readyOut}, 16'h1);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h00F3);
    rd(A_INT, v);  chk("R9 second opcode", v, 16'h8010);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0080);
    @(negedge clk);
    warmRstReq = 1'b1;
    @(negedge clk);
    warmRstReq = 1'b0;
    chk("R9 pin drops busy", {15'b0, busy}, 16'h0);
    rd(A_INT, v);  chk("R9 pin int", v, 16'h8010);
    wr(A_INT, 16'h0000);
    finishOp(1'b1);
    rd(A_INT, v);  chk("R9 stale done ignored", v, 16'h0000);
    rd(A_STAT, v); chk("R9 stale fail ignored", v, 16'h0000);
  endtask

  initial begin
    #(20 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBlockedCmd();
    testAckAndPolarity();
    testStartBuffer();
    testLoad();
    testProgFail();
    testErase();
    testUnknown();
    testImmediateAndBusy();
    testCollision();
    testWarm();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule